// File: doc/BRIEF.md
# Main Clock Stop Detector

This block watches a main clock from a second, free-running sampling clock. It issues a reset request when the main clock stops toggling. Each rising edge of the main clock flips a toggle bit. A synchronizer carries that bit into the sampling domain, where an edge detector restarts an idle counter. If the counter reaches the stop limit, a one-cycle reset request is issued and a sticky cause flag is set. Software can then tell this reset apart from the others.

Software turns monitoring on through a small register port. Once monitoring is on, it can only be turned off by a reset. Four qualifier inputs suspend monitoring while the main clock is stopped or unstable on purpose:

- oscillator settling after a low-power exit,
- the main clock parked during slow-clock operation,
- the sampling oscillator halted,
- the CPU running from the sampling oscillator.

While any qualifier is high, the idle counter is held at zero. The request output goes to the system reset controller, which answers with the system reset. The system reset clears the enable but keeps the cause flag. Only the power-on reset clears the cause flag.

Top module: `mclk_stop_detect`

## Requirements
- R1: While monitoring is enabled and the main clock runs with rising edges no more than 3 sampling cycles apart, `resetReq` stays low.
- R2: Writing `regWdata[0]`=1 with `regWrite` turns monitoring on. A later write with bit 0 = 0 leaves it on. `regRdata[0]` reads the enable state. Either reset (`porN` or `sysRstN` low) turns it off.
- R3: When a request is issued, the cause flag is set in the same cycle. The flag is visible on `causeFlag` and on `regRdata[1]`. It survives a system reset. Only `porN` low clears it.
- R4: When the main clock stops while monitoring is enabled and not suspended, `resetReq` rises within STOP_LIMIT+4 sampling cycles. It is high for exactly one sampling cycle. It does not rise again until the next system or power-on reset.
- R5: While any of `oscSettling`, `mainClkParked`, `sampClkOff` or `cpuOnSampOsc` is high, no request is issued, however long the main clock has been stopped.
- R6: The idle count is held at zero while monitoring is suspended. When the last qualifier falls with the main clock stopped, `resetReq` is high after the STOP_LIMIT-th rising edge of `sampClk`, counting the first edge with all qualifiers low as edge 1. It is low after each earlier edge.
- R7: A write with `regWdata[1]`=1 clears the cause flag. A write with `regWdata[1]`=0 leaves it unchanged.
- R8: If a clearing write and a new request fall in the same sampling cycle, the cause flag ends set.
- R9: While monitoring is disabled, stopping the main clock raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sampClk | input | 1 | Free-running sampling clock; all register and request logic runs on it |
| mainClk | input | 1 | Main clock being watched |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| sysRstN | input | 1 | System reset, active low, asynchronous; keeps the cause flag |
| regWrite | input | 1 | Register write strobe, sampled on `sampClk` |
| regWdata | input | 2 | Bit 0 = set enable, bit 1 = clear cause flag |
| regRdata | output | 2 | Bit 0 = enable state, bit 1 = cause flag |
| oscSettling | input | 1 | Suspend: oscillator settling after a low-power exit |
| mainClkParked | input | 1 | Suspend: main clock deliberately stopped in slow-clock operation |
| sampClkOff | input | 1 | Suspend: sampling oscillator halted |
| cpuOnSampOsc | input | 1 | Suspend: CPU clocked from the sampling oscillator |
| resetReq | output | 1 | One-cycle reset request on a detected stop |
| causeFlag | output | 1 | Sticky flag recording a request from this block |

## Verification
A detected stop sets the cause flag while a software write may be clearing it, both in the same sampling cycle. The bench provokes this collision deterministically. It first stops the main clock under a suspend qualifier. It then releases the qualifier and places a clearing write on the exact edge where the idle count hits its limit. The flag must be read as set afterwards, while `resetReq` is high for that same cycle. The released-qualifier path also pins the request to a known edge, which checks that no stale count survives a suspension.

// File: rtl/mcsd_pkg.sv
package mcsd_pkg;
  // Register bit positions shared by write and read data
  localparam int unsigned EnBit  = 0;
  localparam int unsigned ClrBit = 1;
  localparam int unsigned RegW   = 2;

  // Strobes from control to the idle-counter datapath
  typedef struct packed {
    logic run;    // advance the idle count when no edge is seen
    logic clear;  // force the idle count to zero
  } cntStrobe_t;
endpackage

// File: rtl/mcsd_datapath.sv
module mcsd_datapath
  import mcsd_pkg::*;
#(
  parameter int unsigned STOP_LIMIT  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       mainClk,
  input  logic       sampClk,
  input  logic       rstAllN,
  input  cntStrobe_t strobe,
  output logic       mainEdge,
  output logic       atLimit
);
  localparam int unsigned CntW  = $clog2(STOP_LIMIT + 1);
  localparam int unsigned ChainW = SYNC_STAGES + 1;
  localparam logic [CntW-1:0] LastIdle = CntW'(STOP_LIMIT - 1);

  // Main-clock domain: toggle on every rising edge
  logic togMain;
  always_ff @(posedge mainClk or negedge rstAllN) begin
    if (!rstAllN) togMain <= 1'b0;
    else          togMain <= ~togMain;
  end

  // Sampling domain: synchronizer plus one history stage for edge detect
  logic [ChainW-1:0] syncChain;
  always_ff @(posedge sampClk or negedge rstAllN) begin
    if (!rstAllN) syncChain <= '0;
    else          syncChain <= {syncChain[ChainW-2:0], togMain};
  end

  assign mainEdge = syncChain[ChainW-1] ^ syncChain[ChainW-2];

  // Idle counter: sampling cycles since the last observed main edge
  logic [CntW-1:0] idleCnt;
  always_ff @(posedge sampClk or negedge rstAllN) begin
    if (!rstAllN)                           idleCnt <= '0;
    else if (strobe.clear)                  idleCnt <= '0;
    else if (strobe.run && mainEdge)        idleCnt <= '0;
    else if (strobe.run && idleCnt != LastIdle) idleCnt <= idleCnt + 1'b1;
  end

  assign atLimit = (idleCnt == LastIdle);
endmodule

// File: rtl/mcsd_control.sv
module mcsd_control
  import mcsd_pkg::*;
(
  input  logic            sampClk,
  input  logic            porN,
  input  logic            rstAllN,
  input  logic            regWrite,
  input  logic [RegW-1:0] regWdata,
  input  logic            oscSettling,
  input  logic            mainClkParked,
  input  logic            sampClkOff,
  input  logic            cpuOnSampOsc,
  input  logic            mainEdge,
  input  logic            atLimit,
  output cntStrobe_t      strobe,
  output logic            enabled,
  output logic            causeFlag,
  output logic            resetReq
);
  logic suspended;
  logic tripped;
  logic fire;
  logic setEn;
  logic clrCause;

  assign suspended = oscSettling | mainClkParked | sampClkOff | cpuOnSampOsc;
  assign setEn     = regWrite & regWdata[EnBit];
  assign clrCause  = regWrite & regWdata[ClrBit];

  always_comb begin
    strobe.clear = ~enabled | suspended;
    strobe.run   = enabled & ~suspended & ~tripped;
  end

  assign fire = strobe.run & ~mainEdge & atLimit;

  // Write-once enable, returned to zero only by a reset
  always_ff @(posedge sampClk or negedge rstAllN) begin
    if (!rstAllN)   enabled <= 1'b0;
    else if (setEn) enabled <= 1'b1;
  end

  // One request per reset: the trip latch stops further counting
  always_ff @(posedge sampClk or negedge rstAllN) begin
    if (!rstAllN) begin
      tripped  <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      tripped  <= tripped | fire;
      resetReq <= fire;
    end
  end

  // Cause flag survives the system reset; a new trip beats a clear
  always_ff @(posedge sampClk or negedge porN) begin
    if (!porN)         causeFlag <= 1'b0;
    else if (fire)     causeFlag <= 1'b1;
    else if (clrCause) causeFlag <= 1'b0;
  end
endmodule

// File: rtl/mclk_stop_detect.sv
module mclk_stop_detect
  import mcsd_pkg::*;
#(
  parameter int unsigned STOP_LIMIT  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       sampClk,
  input  logic       mainClk,
  input  logic       porN,
  input  logic       sysRstN,
  input  logic       regWrite,
  input  logic [1:0] regWdata,
  output logic [1:0] regRdata,
  input  logic       oscSettling,
  input  logic       mainClkParked,
  input  logic       sampClkOff,
  input  logic       cpuOnSampOsc,
  output logic       resetReq,
  output logic       causeFlag
);
  logic       rstAllN;
  logic       mainEdge;
  logic       atLimit;
  logic       enabled;
  cntStrobe_t strobe;

  assign rstAllN = porN & sysRstN;

  mcsd_datapath #(
    .STOP_LIMIT (STOP_LIMIT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .mainClk (mainClk),
    .sampClk (sampClk),
    .rstAllN (rstAllN),
    .strobe  (strobe),
    .mainEdge(mainEdge),
    .atLimit (atLimit)
  );

  mcsd_control u_ctl (
    .sampClk      (sampClk),
    .porN         (porN),
    .rstAllN      (rstAllN),
    .regWrite     (regWrite),
    .regWdata     (regWdata),
    .oscSettling  (oscSettling),
    .mainClkParked(mainClkParked),
    .sampClkOff   (sampClkOff),
    .cpuOnSampOsc (cpuOnSampOsc),
    .mainEdge     (mainEdge),
    .atLimit      (atLimit),
    .strobe       (strobe),
    .enabled      (enabled),
    .causeFlag    (causeFlag),
    .resetReq     (resetReq)
  );

  always_comb begin
    regRdata         = '0;
    regRdata[EnBit]  = enabled;
    regRdata[ClrBit] = causeFlag;
  end
endmodule

// File: rtl/mcsd_checker.sv
module mcsd_checker (
  input logic       sampClk,
  input logic       porN,
  input logic       sysRstN,
  input logic [1:0] regRdata,
  input logic       oscSettling,
  input logic       mainClkParked,
  input logic       sampClkOff,
  input logic       cpuOnSampOsc,
  input logic       resetReq,
  input logic       causeFlag
);
  logic anySuspend;
  assign anySuspend = oscSettling | mainClkParked | sampClkOff | cpuOnSampOsc;

  a_r4_single_pulse: assert property (@(posedge sampClk) disable iff (!porN || !sysRstN)
    resetReq |=> !resetReq);

  a_r2_enable_sticky: assert property (@(posedge sampClk) disable iff (!porN || !sysRstN)
    regRdata[0] |=> regRdata[0]);

  a_r3_cause_with_request: assert property (@(posedge sampClk) disable iff (!porN || !sysRstN)
    resetReq |-> (causeFlag && regRdata[1]));

  a_r5_suspend_blocks: assert property (@(posedge sampClk) disable iff (!porN || !sysRstN)
    anySuspend |=> !resetReq);

  a_r9_needs_enable: assert property (@(posedge sampClk) disable iff (!porN || !sysRstN)
    resetReq |-> $past(regRdata[0]));
endmodule

bind mclk_stop_detect mcsd_checker u_chk (
  .sampClk      (sampClk),
  .porN         (porN),
  .sysRstN      (sysRstN),
  .regRdata     (regRdata),
  .oscSettling  (oscSettling),
  .mainClkParked(mainClkParked),
  .sampClkOff   (sampClkOff),
  .cpuOnSampOsc (cpuOnSampOsc),
  .resetReq     (resetReq),
  .causeFlag    (causeFlag)
);

// File: tb/tb_mclk_stop_detect.sv
`timescale 1ns/1ps
module tb_mclk_stop_detect;
  localparam int LIMIT = 4;

  logic       sampClk = 1'b0;
  logic       mainOsc = 1'b0;
  logic       mainRun = 1'b1;
  logic       mainClk;
  logic       porN = 1'b0;
  logic       sysRstN = 1'b0;
  logic       regWrite = 1'b0;
  logic [1:0] regWdata = '0;
  logic [1:0] regRdata;
  logic [3:0] qual = '0;
  logic       resetReq;
  logic       causeFlag;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  int expTrip[$];

  always #4  sampClk = ~sampClk;   // 125 MHz sampling clock
  always #10 mainOsc = ~mainOsc;   // 50 MHz main clock when running
  assign mainClk = mainRun & mainOsc;

  mclk_stop_detect #(.STOP_LIMIT(LIMIT)) dut (
    .sampClk(sampClk), .mainClk(mainClk), .porN(porN), .sysRstN(sysRstN),
    .regWrite(regWrite), .regWdata(regWdata), .regRdata(regRdata),
    .oscSettling(qual[0]), .mainClkParked(qual[1]), .sampClkOff(qual[2]),
    .cpuOnSampOsc(qual[3]), .resetReq(resetReq), .causeFlag(causeFlag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge sampClk);
  endtask

  task automatic wr(input logic [1:0] d);
    regWrite = 1'b1; regWdata = d;
    tick(1);
    regWrite = 1'b0; regWdata = '0;
  endtask

  task automatic sysReset();
    sysRstN = 1'b0; tick(2); sysRstN = 1'b1; tick(1);
  endtask

  // Fresh enabled state with a running main clock and a clear cause flag
  task automatic armFresh();
    mainRun = 1'b1; tick(3);
    sysReset();
    wr(2'b10);
    wr(2'b01);
    tick(10);
  endtask

  // Scoreboard monitor: every request must match a queued expectation
  always @(negedge sampClk) begin
    if (porN && resetReq) begin
      pulseCnt++;
      checks++;
      if (expTrip.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected request actual=1 expected=0");
      end else begin
        void'(expTrip.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    int n;
    tick(3);
    porN = 1'b1; sysRstN = 1'b1; tick(2);
    chk(regRdata == 2'b00, "R2", "reset regRdata", regRdata, 0);
    chk(resetReq == 1'b0, "R4", "reset resetReq", resetReq, 0);

    // R9: disabled monitor ignores a stopped main clock
    base = pulseCnt;
    mainRun = 1'b0; tick(30);
    chk(pulseCnt == base, "R9", "pulses while disabled", pulseCnt - base, 0);
    mainRun = 1'b1; tick(5);

    // R2: write-once enable
    wr(2'b01); tick(1);
    chk(regRdata[0] == 1'b1, "R2", "enable set", regRdata[0], 1);
    wr(2'b00); tick(1);
    chk(regRdata[0] == 1'b1, "R2", "enable after write 0", regRdata[0], 1);

    // R1: running clock raises nothing
    base = pulseCnt;
    tick(60);
    chk(pulseCnt == base, "R1", "pulses while running", pulseCnt - base, 0);

    // R4: stop detection latency and single pulse
    expTrip.push_back(1);
    mainRun = 1'b0;
    n = 0;
    while (!resetReq && n < 30) begin tick(1); n++; end
    chk(resetReq == 1'b1 && n >= 1 && n <= LIMIT + 4, "R4", "stop latency", n, LIMIT);
    chk(causeFlag == 1'b1, "R3", "cause set with request", causeFlag, 1);
    tick(1);
    chk(resetReq == 1'b0, "R4", "pulse width one cycle", resetReq, 0);
    base = pulseCnt;
    tick(20);
    chk(pulseCnt == base, "R4", "no second request", pulseCnt - base, 0);

    // R3: system reset keeps cause, clears enable
    sysReset();
    chk(regRdata == 2'b10, "R3", "after system reset regRdata", regRdata, 2);
    // R7: write 0 to clear bit keeps, write 1 clears
    wr(2'b00); tick(1);
    chk(causeFlag == 1'b1, "R7", "cause after write 0", causeFlag, 1);
    wr(2'b10); tick(1);
    chk(causeFlag == 1'b0 && regRdata[1] == 1'b0, "R7", "cause after clear", causeFlag, 0);

    // R5 and R6 for every qualifier
    for (int q = 0; q < 4; q++) begin
      armFresh();
      qual[q] = 1'b1; tick(2);
      mainRun = 1'b0;
      base = pulseCnt;
      tick(30);
      chk(pulseCnt == base, "R5", $sformatf("pulses with qualifier %0d", q), pulseCnt - base, 0);
      expTrip.push_back(2 + q);
      qual[q] = 1'b0;
      for (int e = 1; e < LIMIT; e++) begin
        tick(1);
        chk(resetReq == 1'b0, "R6", $sformatf("early edge %0d", e), resetReq, 0);
      end
      tick(1);
      chk(resetReq == 1'b1, "R6", "request on limit edge", resetReq, 1);
      tick(1);
      chk(resetReq == 1'b0, "R6", "request drops", resetReq, 0);
    end

    // R8: clearing write collides with a new request
    armFresh();
    qual[1] = 1'b1; tick(2);
    mainRun = 1'b0; tick(10);
    expTrip.push_back(9);
    qual[1] = 1'b0;
    tick(LIMIT - 1);
    regWrite = 1'b1; regWdata = 2'b10;
    tick(1);
    regWrite = 1'b0; regWdata = '0;
    chk(resetReq == 1'b1, "R8", "request in collision cycle", resetReq, 1);
    chk(causeFlag == 1'b1, "R8", "cause after collision", causeFlag, 1);

    // R3: power-on reset clears the cause flag
    tick(2);
    porN = 1'b0; tick(2); porN = 1'b1; tick(1);
    chk(causeFlag == 1'b0 && regRdata == 2'b00, "R3", "after power-on reset", regRdata, 0);

    chk(expTrip.size() == 0, "R4", "expected requests outstanding", expTrip.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule